// File: doc/BRIEF.md
# Single-Level Page Walk Translator

This block turns a virtual byte address into a physical byte address by reading one entry from a page table in memory. A request carries the virtual address, whether the access writes or reads, and whether the requester runs in user or supervisor mode. The block takes the upper part of the virtual address as an index into the table, which starts at a programmable base address. It issues one read on a simple memory read port, and waits however many cycles the memory needs. It then checks the entry's presence and permission bits and returns either a physical address or a fault code.

Only one translation is in flight at a time. The request side is a valid/ready stream: `req_ready` is high only while the block is idle and no base update is being applied in that cycle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response side is also valid/ready: once `rsp_valid` rises, the response stays up and unchanged until `rsp_ready` is seen high on a clock edge. The block never drops a response, and it stalls new requests for as long as the consumer holds `rsp_ready` low.

The base address is a plain control input and is applied only while the block is idle. Page size, virtual and physical widths and entry width are parameters. The defaults are 4 KiB pages, 32-bit virtual addresses, 24-bit physical addresses and 32-bit entries.

Top module: `pt_xlate_unit`

## Requirements
- R1: After a request is taken, `mem_rd_req` is high from the next cycle with `mem_rd_addr` = base + (vaddr[31:12] * 4), modulo 2^32. Both hold steady until `mem_rd_valid` is seen high, for any memory latency including zero extra cycles.
- R2: For an entry that is present and grants the access, the response carries fault code 00 and physical address {entry[11:0], vaddr[11:0]}. Entry bits 27:12 are ignored.
- R3: If entry bit 31 (present) is 0, the fault code is 01 whatever the other bits hold, and the physical address is all zeros. Every faulted response carries an all-zero address.
- R4: A user-mode request (`req_user`=1) to a present entry with bit 28 (supervisor-only) set gets fault code 11. This check ranks above the read and write checks.
- R5: A write to a present entry that the requester may use, with bit 29 (writable) clear, gets fault code 10.
- R6: A read to a present entry that the requester may use, with bit 30 (readable) clear, gets fault code 10. A write does not need bit 30.
- R7: A supervisor-mode request may use both supervisor-only and user entries.
- R8: `req_ready` is low from the cycle after a request is taken until the cycle after its response is taken, and in any cycle where `base_wr_en` is high.
- R9: `base_wr_data` is loaded into the base when `base_wr_en` is high and the block is idle. A write while a translation is in flight has no effect.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R11: `rsp_valid` rises exactly two clock edges after the edge at which `mem_rd_valid` is seen high.
- R12: After reset, `req_ready` is 1, `rsp_valid` and `mem_rd_req` are 0, and the base is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the table base (applied only when idle) |
| base_wr_data | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| mem_rd_req | output | 1 | Entry read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_valid | input | 1 | Entry data is valid this cycle |
| mem_rd_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 24 | Physical byte address (zero on fault) |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 access denied, 11 privilege |

## Verification
The bound checker watches properties that must hold in every cycle:
- the entry read stays stable while unanswered;
- the response stays stable under back-pressure;
- a taken request leads straight into a read;
- a ready request side excludes both a pending read and a pending response;
- faulted addresses are zero;
- the page offset passes through unchanged;
- the base stays frozen while a walk is in flight.

Only the bench scenarios can show other behaviour:
- the fault code chosen for each mix of entry bits, access type and mode, including the priority order;
- the exact response latency after the memory answers;
- the effect of the base and of an ignored mid-walk base write on later entry addresses.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_CHECK   = 2'd2,
    ST_RESPOND = 2'd3
  } ptx_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_ACCESS = 2'b10,
    FLT_PRIV   = 2'b11
  } ptx_fault_e;

endpackage

// File: rtl/ptx_base_reg.sv
module ptx_base_reg #(
  parameter int MA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            idle,
  input  logic [MA_W-1:0] wr_data,
  output logic [MA_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (wr_en && idle) begin
      base_q <= wr_data;
    end
  end

endmodule

// File: rtl/ptx_perm_check.sv
module ptx_perm_check
  import ptx_pkg::*;
#(
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int PTE_W   = 32
) (
  input  logic [PTE_W-1:0]   pte,
  input  logic               is_write,
  input  logic               is_user,
  input  logic [PG_BITS-1:0] offset,
  output ptx_fault_e         fault,
  output logic [PA_W-1:0]    paddr
);

  localparam int PPN_W   = PA_W - PG_BITS;
  localparam int BIT_V   = PTE_W - 1;
  localparam int BIT_R   = PTE_W - 2;
  localparam int BIT_W   = PTE_W - 3;
  localparam int BIT_S   = PTE_W - 4;
  localparam int RSV_LO  = PPN_W;
  localparam int RSV_HI  = PTE_W - 5;

  logic pres, may_rd, may_wr, sup_only;
  logic [PPN_W-1:0] ppn;

  assign pres     = pte[BIT_V];
  assign may_rd   = pte[BIT_R];
  assign may_wr   = pte[BIT_W];
  assign sup_only = pte[BIT_S];
  assign ppn      = pte[PPN_W-1:0];

  generate
    if (RSV_HI >= RSV_LO) begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = ^pte[RSV_HI:RSV_LO];
    end
  endgenerate

  always_comb begin
    if (!pres) begin
      fault = FLT_ABSENT;
    end else if (is_user && sup_only) begin
      fault = FLT_PRIV;
    end else if (is_write && !may_wr) begin
      fault = FLT_ACCESS;
    end else if (!is_write && !may_rd) begin
      fault = FLT_ACCESS;
    end else begin
      fault = FLT_NONE;
    end
  end

  always_comb begin
    if (fault == FLT_NONE) begin
      paddr = {ppn, offset};
    end else begin
      paddr = '0;
    end
  end

endmodule

// File: rtl/ptx_walker.sv
module ptx_walker
  import ptx_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int PTE_W   = 32,
  parameter int MA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MA_W-1:0]    base,
  input  logic               hold_off,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_rd_req,
  output logic [MA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [PTE_W-1:0]   mem_rd_data,
  output logic [PTE_W-1:0]   pte_q,
  output logic [PG_BITS-1:0] off_q,
  output logic               write_q,
  output logic               user_q,
  input  ptx_fault_e         fault_in,
  input  logic [PA_W-1:0]    paddr_in,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault,
  output logic               idle
);

  localparam int VPN_W     = VA_W - PG_BITS;
  localparam int PTE_BYTES = PTE_W / 8;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  ptx_state_e       state_q, state_d;
  logic [MA_W-1:0]  ent_addr_q;
  logic [MA_W-1:0]  vpn_ext;
  logic [MA_W-1:0]  ent_addr_d;
  logic [PA_W-1:0]  paddr_q;
  ptx_fault_e       fault_q;
  logic             accept;

  assign idle      = (state_q == ST_IDLE);
  assign req_ready = idle && !hold_off;
  assign accept    = req_valid && req_ready;

  assign vpn_ext    = MA_W'(req_vaddr[VA_W-1:PG_BITS]);
  assign ent_addr_d = base + (vpn_ext << PTE_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept)       state_d = ST_FETCH;
      ST_FETCH:   if (mem_rd_valid) state_d = ST_CHECK;
      ST_CHECK:                     state_d = ST_RESPOND;
      ST_RESPOND: if (rsp_ready)    state_d = ST_IDLE;
      default:                      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ent_addr_q <= '0;
      off_q      <= '0;
      write_q    <= 1'b0;
      user_q     <= 1'b0;
      pte_q      <= '0;
      paddr_q    <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ent_addr_q <= ent_addr_d;
        off_q      <= req_vaddr[PG_BITS-1:0];
        write_q    <= req_write;
        user_q     <= req_user;
      end
      if (state_q == ST_FETCH && mem_rd_valid) begin
        pte_q <= mem_rd_data;
      end
      if (state_q == ST_CHECK) begin
        paddr_q <= paddr_in;
        fault_q <= fault_in;
      end
    end
  end

  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_rd_addr = ent_addr_q;
  assign rsp_valid   = (state_q == ST_RESPOND);
  assign rsp_paddr   = paddr_q;
  assign rsp_fault   = fault_q;

  logic unused_vpn_w;
  assign unused_vpn_w = (VPN_W > 0);

endmodule

// File: rtl/pt_xlate_unit.sv
module pt_xlate_unit
  import ptx_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int PTE_W   = 32,
  parameter int MA_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               base_wr_en,
  input  logic [MA_W-1:0]    base_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               mem_rd_req,
  output logic [MA_W-1:0]    mem_rd_addr,
  input  logic               mem_rd_valid,
  input  logic [PTE_W-1:0]   mem_rd_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [1:0]         rsp_fault
);

  logic [MA_W-1:0]    base_q;
  logic               idle_w;
  logic               busy;
  logic [PTE_W-1:0]   pte_w;
  logic [PG_BITS-1:0] off_w;
  logic               write_w, user_w;
  ptx_fault_e         fault_w;
  logic [PA_W-1:0]    paddr_w;

  assign busy = !idle_w;

  ptx_base_reg #(.MA_W(MA_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .idle    (idle_w),
    .wr_data (base_wr_data),
    .base_q  (base_q)
  );

  ptx_walker #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS), .PTE_W(PTE_W), .MA_W(MA_W)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .base         (base_q),
    .hold_off     (base_wr_en),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vaddr    (req_vaddr),
    .req_write    (req_write),
    .req_user     (req_user),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .pte_q        (pte_w),
    .off_q        (off_w),
    .write_q      (write_w),
    .user_q       (user_w),
    .fault_in     (fault_w),
    .paddr_in     (paddr_w),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_paddr    (rsp_paddr),
    .rsp_fault    (rsp_fault),
    .idle         (idle_w)
  );

  ptx_perm_check #(
    .PA_W(PA_W), .PG_BITS(PG_BITS), .PTE_W(PTE_W)
  ) u_perm (
    .pte      (pte_w),
    .is_write (write_w),
    .is_user  (user_w),
    .offset   (off_w),
    .fault    (fault_w),
    .paddr    (paddr_w)
  );

endmodule

// File: rtl/ptx_xlate_checks.sv
module ptx_xlate_checks #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int MA_W    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            mem_rd_req,
  input logic [MA_W-1:0] mem_rd_addr,
  input logic            mem_rd_valid,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            busy,
  input logic [MA_W-1:0] base_q
);

  logic [PG_BITS-1:0] off_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) off_seen <= '0;
    else if (req_valid && req_ready) off_seen <= req_vaddr[PG_BITS-1:0];
  end

  assert_walk_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_req);

  assert_read_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'b00) |-> (rsp_paddr[PG_BITS-1:0] == off_seen));

  assert_fault_zero_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));

  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_req && !rsp_valid));

  assert_base_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

endmodule

bind pt_xlate_unit ptx_xlate_checks #(
  .VA_W(VA_W), .PA_W(PA_W), .PG_BITS(PG_BITS), .MA_W(MA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_vaddr    (req_vaddr),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_addr  (mem_rd_addr),
  .mem_rd_valid (mem_rd_valid),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .busy         (busy),
  .base_q       (base_q)
);

// File: tb/pt_xlate_unit_test.sv
`timescale 1ns/1ps
module pt_xlate_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [23:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pt_xlate_unit uut (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [31:0] pte;
    logic [3:0]  lat;
    logic [1:0]  flt;
    logic [23:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_3ABC, 1'b0, 1'b0, 32'hE000_005A, 4'd0, 2'b00, 24'h05AABC}, // R2 sup read
    '{32'h1234_5678, 1'b1, 1'b1, 32'hE000_0FFF, 4'd3, 2'b00, 24'hFFF678}, // R2 user write
    '{32'h0000_1000, 1'b0, 1'b1, 32'h7000_0123, 4'd1, 2'b01, 24'h000000}, // R3 absent
    '{32'h0000_2004, 1'b0, 1'b1, 32'hF000_0010, 4'd2, 2'b11, 24'h000000}, // R4 priv
    '{32'h0000_2008, 1'b1, 1'b1, 32'h9000_0010, 4'd5, 2'b11, 24'h000000}, // R4 over R5
    '{32'h0000_4444, 1'b1, 1'b0, 32'hC000_0020, 4'd0, 2'b10, 24'h000000}, // R5 no write
    '{32'h0000_4448, 1'b0, 1'b1, 32'hA000_0020, 4'd4, 2'b10, 24'h000000}, // R6 no read
    '{32'hFFFF_FFFF, 1'b1, 1'b1, 32'hA000_0321, 4'd2, 2'b00, 24'h321FFF}, // R6 write w/o read
    '{32'h0000_0000, 1'b0, 1'b0, 32'hD000_0777, 4'd1, 2'b00, 24'h777000}, // R7 sup on sup page
    '{32'h0000_5FFE, 1'b0, 1'b1, 32'hE0AB_C001, 4'd0, 2'b00, 24'h001FFE}  // R2 reserved ignored
  };

  task automatic xlate(input logic [31:0] va, input logic wr, input logic usr,
                       input logic [31:0] pte, input int lat, input int stall,
                       input bit poke, input logic [31:0] poke_val,
                       input logic [31:0] base_exp, input logic [1:0] eflt,
                       input logic [23:0] epa, input string tag);
    logic [31:0] eaddr;
    logic [23:0] pa_seen;
    logic [1:0]  f_seen;
    eaddr = base_exp + ({12'd0, va[31:12]} << 2);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {"R8 busy ready ", tag}, {31'd0, req_ready}, 32'd0);
    chk(mem_rd_req == 1'b1, {"R1 read req ", tag}, {31'd0, mem_rd_req}, 32'd1);
    chk(mem_rd_addr == eaddr, {"R1 entry addr ", tag}, mem_rd_addr, eaddr);
    if (poke) begin
      base_wr_en = 1'b1; base_wr_data = poke_val;
      @(negedge clk);
      base_wr_en = 1'b0;
    end
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_rd_req && mem_rd_addr == eaddr, {"R1 held ", tag}, mem_rd_addr, eaddr);
    end
    mem_rd_valid = 1'b1; mem_rd_data = pte;
    @(negedge clk);
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    chk(rsp_valid == 1'b0, {"R11 early ", tag}, {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, {"R11 latency ", tag}, {31'd0, rsp_valid}, 32'd1);
    chk(rsp_fault == eflt, {"fault ", tag}, {30'd0, rsp_fault}, {30'd0, eflt});
    chk(rsp_paddr == epa, {"paddr ", tag}, {8'd0, rsp_paddr}, {8'd0, epa});
    pa_seen = rsp_paddr; f_seen = rsp_fault;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa_seen && rsp_fault == f_seen,
          {"R10 hold ", tag}, {8'd0, rsp_paddr}, {8'd0, pa_seen});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, {"R8 back to idle ", tag},
        {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_ready == 1'b1, "R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk(rsp_valid == 1'b0, "R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk(mem_rd_req == 1'b0, "R12 mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: base is zero, so entry address is vpn*4
    xlate(32'h0000_7123, 1'b0, 1'b0, 32'hC000_0042, 1, 0, 1'b0, 32'd0,
          32'd0, 2'b00, 24'h042123, "R12 zero base");

    // R8/R9: base write in the same cycle as a request holds the request off
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = 32'h0001_0000; req_valid = 1'b1;
    req_vaddr = 32'h0; req_write = 1'b0; req_user = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R8 ready low during base write", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    base_wr_en = 1'b0; req_valid = 1'b0;

    for (int k = 0; k < NV; k++) begin
      xlate(VECS[k].va, VECS[k].wr, VECS[k].usr, VECS[k].pte, int'(VECS[k].lat),
            0, 1'b0, 32'd0, 32'h0001_0000, VECS[k].flt, VECS[k].pa,
            $sformatf("vec%0d", k));
    end

    // R9: base write while a walk is in flight is ignored
    xlate(32'h0000_9010, 1'b0, 1'b0, 32'hC000_0ABC, 2, 0, 1'b1, 32'hDEAD_0000,
          32'h0001_0000, 2'b00, 24'hABC010, "R9 poke");
    xlate(32'h0000_A020, 1'b0, 1'b0, 32'hC000_0ABD, 0, 0, 1'b0, 32'd0,
          32'h0001_0000, 2'b00, 24'hABD020, "R9 base unchanged");

    // R10: back-pressure on the response
    xlate(32'h0000_B030, 1'b1, 1'b0, 32'hE000_0555, 1, 3, 1'b0, 32'd0,
          32'h0001_0000, 2'b00, 24'h555030, "R10 stall");
    xlate(32'h0000_C040, 1'b0, 1'b1, 32'h0000_0000, 0, 2, 1'b0, 32'd0,
          32'h0001_0000, 2'b01, 24'h000000, "R3 R10 stall fault");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule